// File: doc/BRIEF.md
# Multi-Mode Data Address Generator

This unit forms the effective address of a load or store in a load/store datapath. Each cycle that a request is presented, it reads an addressing mode, a base pointer, an index value, a signed displacement and an element size. One clock later it returns the memory address to use. For the modes that modify a pointer after use, it also returns the updated base value and a write-back strobe, which the register file uses to store that value back.

The modes cover the general-purpose forms: register indirect, base plus displacement, base plus index, and scaled index. They also cover the pointer-stepping forms that signal-processing loops use. These are post-increment, post-decrement, a circular post-increment that wraps inside a window set by a start and an end pointer, and a reverse-carry increment that walks a power-of-two buffer in bit-reversed order for FFT passes. A flag reports an address that is not a multiple of the element size. The unit raises no trap.

Top module: `agu_top`

## Requirements
- R1: While `rst_n` is low, `out_vld` and `base_we` are 0.
- R2: `out_vld` equals `req_vld` of the previous cycle. When no request is made, `eff_addr`, `base_next` and `misalign` keep their previous values.
- R3: Mode code 0 (indirect) gives `eff_addr` = `base`.
- R4: Mode code 1 (displacement) gives `eff_addr` = `base` + `disp`, with `disp` sign-extended to the address width.
- R5: Mode code 2 (indexed) gives `eff_addr` = `base` + `index`.
- R6: Mode code 3 (scaled) gives `eff_addr` = `base` + sign-extended `disp` + (`index` << `size_code`). `size_code` values 0, 1, 2 and 3 select element sizes of 1, 2, 4 and 8 bytes.
- R7: Mode code 4 (post-increment) gives `eff_addr` = `base` and `base_next` = `base` + element size.
- R8: Mode code 5 (post-decrement) gives `eff_addr` = `base` and `base_next` = `base` − element size.
- R9: Mode code 6 (circular) gives `eff_addr` = `base`. `base_next` is `base` + element size when that sum is at most `circ_end` (unsigned compare), and `circ_start` otherwise.
- R10: Mode code 7 (bit-reversed) gives `eff_addr` = `base`. In `base_next`, the low `BR_LOG2` bits are the reverse-carry sum of the current offset and the element size, with carries moving from the highest offset bit toward bit 0. The bits above are unchanged.
- R11: `base_we` is 1 exactly one cycle after a request whose mode code is 4 to 7, and 0 otherwise.
- R12: `misalign` is 1 exactly when `eff_addr` is not a multiple of the element size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing mode code (0 to 7) |
| size_code | input | 2 | Element size as log2 of the byte count |
| base | input | AW | Base pointer value |
| index | input | AW | Index value |
| disp | input | DISP_W | Signed displacement |
| circ_start | input | AW | Circular window start pointer |
| circ_end | input | AW | Circular window end pointer |
| out_vld | output | 1 | Result valid |
| eff_addr | output | AW | Effective address |
| base_next | output | AW | Updated base pointer |
| base_we | output | 1 | Base write-back strobe |
| misalign | output | 1 | Address not a multiple of the element size |

## Verification
The first stimulus is directed: each mode with small values where the expected address is easy to read. This separates the operand paths from one another and tests the sign of the displacement with negative values. Further directed cases cover the circular step landing exactly on the end pointer, one step past it, and a full bit-reversed walk of the buffer for several element sizes. Together these tell a correct wrap compare from an off-by-one, and a reverse carry from an ordinary carry. A random stream with idle gaps then mixes all modes and sizes and checks hold behaviour and the misalignment flag against the bench model on every clock.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    AM_IND   = 3'd0,
    AM_DISP  = 3'd1,
    AM_IDX   = 3'd2,
    AM_SCALE = 3'd3,
    AM_PINC  = 3'd4,
    AM_PDEC  = 3'd5,
    AM_CIRC  = 3'd6,
    AM_BREV  = 3'd7
  } am_e;

  function automatic logic is_postmod(input logic [2:0] m);
    return m[2];
  endfunction
endpackage

// File: rtl/agu_ea.sv
module agu_ea #(
  parameter int AW     = 32,
  parameter int DISP_W = 16
) (
  input  logic [2:0]        mode,
  input  logic [1:0]        size_code,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     index,
  input  logic [DISP_W-1:0] disp,
  output logic [AW-1:0]     ea,
  output logic              mis
);
  import agu_pkg::*;
  logic [AW-1:0] disp_x;
  logic [AW-1:0] idx_sh;
  logic [AW-1:0] lowmask;

  assign disp_x = {{(AW-DISP_W){disp[DISP_W-1]}}, disp};
  assign idx_sh = index << size_code;

  always_comb begin
    unique case (am_e'(mode))
      AM_DISP:  ea = base + disp_x;
      AM_IDX:   ea = base + index;
      AM_SCALE: ea = base + disp_x + idx_sh;
      default:  ea = base;
    endcase
  end

  always_comb begin
    lowmask = '0;
    unique case (size_code)
      2'd0: lowmask[2:0] = 3'b000;
      2'd1: lowmask[2:0] = 3'b001;
      2'd2: lowmask[2:0] = 3'b011;
      default: lowmask[2:0] = 3'b111;
    endcase
  end

  assign mis = |(ea & lowmask);
endmodule

// File: rtl/agu_step.sv
module agu_step #(
  parameter int AW      = 32,
  parameter int BR_LOG2 = 6
) (
  input  logic [2:0]    mode,
  input  logic [1:0]    size_code,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] circ_start,
  input  logic [AW-1:0] circ_end,
  output logic [AW-1:0] nxt
);
  import agu_pkg::*;
  localparam int BL = BR_LOG2;

  logic [AW-1:0] step;
  logic [AW-1:0] inc;
  logic [BL-1:0] off;
  logic [BL-1:0] addv;
  logic [BL-1:0] cin;
  logic [BL-1:0] rsum;

  assign step = AW'(1) << size_code;
  assign inc  = base + step;
  assign off  = base[BL-1:0];
  assign addv = step[BL-1:0];

  // reverse-carry adder: carry ripples from MSB of the offset toward bit 0
  always_comb begin
    cin = '0;
    for (int i = BL - 1; i >= 1; i--) begin
      cin[i-1] = (off[i] & addv[i]) | (off[i] & cin[i]) | (addv[i] & cin[i]);
    end
  end

  generate
    for (genvar g = 0; g < BL; g++) begin : g_rbit
      assign rsum[g] = off[g] ^ addv[g] ^ cin[g];
    end
  endgenerate

  always_comb begin
    unique case (am_e'(mode))
      AM_PINC: nxt = inc;
      AM_PDEC: nxt = base - step;
      AM_CIRC: nxt = (inc > circ_end) ? circ_start : inc;
      AM_BREV: nxt = {base[AW-1:BL], rsum};
      default: nxt = base;
    endcase
  end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int AW      = 32,
  parameter int DISP_W  = 16,
  parameter int BR_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic [2:0]        mode,
  input  logic [1:0]        size_code,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     index,
  input  logic [DISP_W-1:0] disp,
  input  logic [AW-1:0]     circ_start,
  input  logic [AW-1:0]     circ_end,
  output logic              out_vld,
  output logic [AW-1:0]     eff_addr,
  output logic [AW-1:0]     base_next,
  output logic              base_we,
  output logic              misalign
);
  import agu_pkg::*;

  logic [AW-1:0] ea_d;
  logic          mis_d;
  logic [AW-1:0] nxt_d;
  logic          we_d;

  agu_ea #(.AW(AW), .DISP_W(DISP_W)) u_ea (
    .mode(mode), .size_code(size_code), .base(base), .index(index),
    .disp(disp), .ea(ea_d), .mis(mis_d)
  );

  agu_step #(.AW(AW), .BR_LOG2(BR_LOG2)) u_step (
    .mode(mode), .size_code(size_code), .base(base),
    .circ_start(circ_start), .circ_end(circ_end), .nxt(nxt_d)
  );

  always_comb begin
    we_d = req_vld & is_postmod(mode);
  end

  // control registers update every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      base_we <= 1'b0;
    end else begin
      out_vld <= req_vld;
      base_we <= we_d;
    end
  end

  // data registers load only on a request (clock enable)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_addr  <= '0;
      base_next <= '0;
      misalign  <= 1'b0;
    end else if (req_vld) begin
      eff_addr  <= ea_d;
      base_next <= nxt_d;
      misalign  <= mis_d;
    end
  end

  assert_we_needs_vld_R11: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> out_vld);

  assert_no_we_plain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !mode[2]) |=> !base_we);

  assert_byte_aligned_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && size_code == 2'd0) |=> !misalign);

  assert_pinc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && mode == 3'd4) |=>
      (base_next == eff_addr + (AW'(1) << $past(size_code))));

  assert_pdec_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && mode == 3'd5) |=>
      (base_next == eff_addr - (AW'(1) << $past(size_code))));

  assert_circ_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && mode == 3'd6) |=>
      (base_next == $past(circ_start) || base_next <= $past(circ_end)));

  assert_brev_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && mode == 3'd7) |=>
      (base_next[AW-1:BR_LOG2] == eff_addr[AW-1:BR_LOG2]));

  assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> out_vld);
endmodule

// File: tb/sim_agu_top.sv
module sim_agu_top;
  localparam int AW = 32;
  localparam int DW = 16;
  localparam int BL = 4;

  logic clk, rst_n, req_vld;
  logic [2:0] mode;
  logic [1:0] size_code;
  logic [AW-1:0] base, index, circ_start, circ_end;
  logic [DW-1:0] disp;
  logic out_vld, base_we, misalign;
  logic [AW-1:0] eff_addr, base_next;

  int total = 0;
  int bad = 0;
  logic [AW-1:0] x_ea, x_nxt;
  logic x_mis;

  agu_top #(.AW(AW), .DISP_W(DW), .BR_LOG2(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .mode(mode),
    .size_code(size_code), .base(base), .index(index), .disp(disp),
    .circ_start(circ_start), .circ_end(circ_end), .out_vld(out_vld),
    .eff_addr(eff_addr), .base_next(base_next), .base_we(base_we),
    .misalign(misalign)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic string tag(input int m);
    case (m)
      0: return "R3"; 1: return "R4"; 2: return "R5"; 3: return "R6";
      4: return "R7"; 5: return "R8"; 6: return "R9"; default: return "R10";
    endcase
  endfunction

  function automatic int rev(input int v);
    int r = 0;
    for (int i = 0; i < BL; i++) if ((v >> i) & 1) r |= 1 << (BL - 1 - i);
    return r;
  endfunction

  task automatic chk(input string t, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input int m, input int sc,
                      input logic [AW-1:0] b, input logic [AW-1:0] ix,
                      input logic [DW-1:0] d, input logic [AW-1:0] cs,
                      input logic [AW-1:0] ce);
    longint sz;
    longint sd;
    longint a;
    longint n;
    int off;
    sz = longint'(1) << sc;
    sd = longint'($signed(d));
    req_vld = v; mode = m[2:0]; size_code = sc[1:0];
    base = b; index = ix; disp = d; circ_start = cs; circ_end = ce;
    if (v) begin
      case (m)
        1: a = longint'(b) + sd;
        2: a = longint'(b) + longint'(ix);
        3: a = longint'(b) + sd + (longint'(ix) << sc);
        default: a = longint'(b);
      endcase
      n = longint'(b);
      case (m)
        4: n = longint'(b) + sz;
        5: n = longint'(b) - sz;
        6: begin
          n = (longint'(b) + sz) & 64'hFFFF_FFFF;
          if (n > longint'(ce)) n = longint'(cs);
        end
        7: begin
          off = int'(b) & ((1 << BL) - 1);
          off = rev((rev(off) + (sc < BL ? (1 << (BL - 1 - sc)) : 0)) & ((1 << BL) - 1));
          n = (longint'(b) & ~longint'((1 << BL) - 1)) | off;
        end
        default: ;
      endcase
      x_ea  = a[AW-1:0];
      x_nxt = n[AW-1:0];
      x_mis = (x_ea & AW'(sz - 1)) != 0;
    end
    @(negedge clk);
    chk("R2", "out_vld", out_vld, v);
    chk(v ? tag(m) : "R2", "eff_addr", eff_addr, x_ea);
    chk(v ? tag(m) : "R2", "base_next", base_next, x_nxt);
    chk("R12", "misalign", misalign, x_mis);
    chk("R11", "base_we", base_we, v && m >= 4);
  endtask

  initial begin
    rst_n = 1'b0; req_vld = 0; mode = 0; size_code = 0; base = 0; index = 0;
    disp = 0; circ_start = 0; circ_end = 0;
    x_ea = 0; x_nxt = 0; x_mis = 0;
    repeat (3) @(negedge clk);
    chk("R1", "out_vld", out_vld, 0);
    chk("R1", "base_we", base_we, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed per mode
    step(1, 0, 2, 32'h1000, 32'h5, 16'h0, 0, 0);
    step(1, 1, 2, 32'h1000, 32'h5, 16'hFFF8, 0, 0);
    step(1, 1, 0, 32'h1000, 32'h5, 16'h0123, 0, 0);
    step(1, 2, 1, 32'h1000, 32'h7, 16'h0, 0, 0);
    step(1, 3, 3, 32'h1000, 32'h3, 16'hFFFC, 0, 0);
    step(1, 3, 1, 32'h2000, 32'h10, 16'h0002, 0, 0);
    step(1, 4, 2, 32'h3000, 0, 0, 0, 0);
    step(1, 5, 3, 32'h3000, 0, 0, 0, 0);
    step(1, 5, 0, 32'h0, 0, 0, 0, 0);
    // circular: land on end, then step past it
    step(1, 6, 2, 32'h10C, 0, 0, 32'h100, 32'h110);
    step(1, 6, 2, 32'h110, 0, 0, 32'h100, 32'h110);
    step(1, 6, 3, 32'h10C, 0, 0, 32'h100, 32'h110);
    // idle: data holds
    step(0, 0, 0, 32'hDEAD, 32'h1, 16'h1, 0, 0);
    step(0, 7, 3, 32'hBEEF, 32'h1, 16'h1, 0, 0);
    // bit-reversed walks
    for (int sc = 0; sc < 3; sc++) begin
      logic [AW-1:0] p;
      p = 32'h4000;
      for (int k = 0; k < 18; k++) begin
        step(1, 7, sc, p, 0, 0, 0, 0);
        p = base_next;
      end
    end
    // random stream
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] cs;
      cs = $urandom;
      step(($urandom % 5) != 0, $urandom % 8, $urandom % 4, $urandom, $urandom,
           DW'($urandom), cs, cs + ($urandom % 256));
    end
    // reset mid-stream
    req_vld = 1; mode = 3'd4;
    rst_n = 1'b0;
    #1;
    chk("R1", "out_vld", out_vld, 0);
    chk("R1", "base_we", base_we, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule